// File: doc/BRIEF.md
# Two-Cycle Capture and XOR Logger

This block drives a target datapath through paired trials. Each trial runs one cycle at normal timing and then a second cycle that either keeps normal timing or is shortened by switching the target onto a fast clock. The target output of the first cycle and the target output of the second cycle go into two separate registers. Their XOR is written into an on-chip result memory, one entry per trial.

When the short cycle produces no fault, a stored entry equals F(a)^key0^F(b)^key1. When the short cycle catches the early, partly updated value, the entry collapses to key0^key1. Here F is the target's substitution function, a is the first input and b is the second.

A sweep keeps the first input fixed. The second input climbs through every value of the data width, and each value is repeated a parameterised number of times. Clock generation lies outside the block: the block sees the two clocks as enables (`norm_tick`, `fast_tick`) and tells the clock multiplexer which one to use through `clk_sel`.

The controller has five states:
- ST_IDLE: waits after reset.
- ST_FIRST: presents the first input in slot 0 and captures on a normal tick.
- ST_SECOND: presents the swept input in slot 1 and captures on the selected tick.
- ST_STORE: writes the XOR and advances the counters.
- ST_DONE: holds after a sweep.

The state transitions are:
- IDLE→FIRST on `start`.
- FIRST→SECOND on `norm_tick`.
- SECOND→STORE on the selected tick.
- STORE→FIRST when trials remain.
- STORE→DONE after the last trial.
- DONE→FIRST on `start`.

Top module: `glitch_pair_logger`

## Requirements
- R1: After reset, `busy`, `done`, `full` and `clk_sel` are 0 and `trial_cnt` is 0.
- R2: In the first cycle of a trial, `dp_slot`=0, `dp_x` holds the first input and `clk_sel`=0. The first register loads `dp_z` on a `norm_tick`.
- R3: In the second cycle, `dp_slot`=1 and `clk_sel` equals the mode latched for the trial (1 = fast). With fast mode the second register loads `dp_z` on `fast_tick`; otherwise it loads on `norm_tick` and `clk_sel` stays 0.
- R4: `clk_sel` falls back to 0 in the cycle after the short-cycle capture.
- R5: Each trial writes first-register XOR second-register to the current write address. The address then advances by one and wraps from 2^ADDR_W-1 to 0.
- R6: Trial t presents second input t/REPS. Inputs ascend from 0 to 2^DATA_W-1, and each value is used for REPS consecutive trials.
- R7: A sweep runs 2^DATA_W·REPS trials and then sets `done`=1 and `busy`=0. `trial_cnt` counts the trials completed in the sweep, and `start` clears it to 0.
- R8: `full` rises when the 2^ADDR_W-th write lands. It stays set until reset.
- R9: The first input is sampled once per sweep at `start`. `use_fast` is sampled at the start of each trial. Later changes to the `x1` pin do not affect the sweep in progress.
- R10: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a sweep |
| x1 | input | DATA_W | First input for the sweep |
| use_fast | input | 1 | 1: shorten the second cycle |
| norm_tick | input | 1 | Normal clock enable |
| fast_tick | input | 1 | Fast clock enable |
| dp_x | output | DATA_W | Input presented to target |
| dp_slot | output | 1 | Target slot (0 first, 1 second) |
| dp_z | input | DATA_W | Target output |
| clk_sel | output | 1 | Clock select to target (1 fast) |
| rd_addr | input | ADDR_W | Result memory read address |
| rd_data | output | DATA_W | Result memory read data |
| trial_cnt | output | DATA_W+REP_W+1 | Trials completed in sweep |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished |
| full | output | 1 | Result memory filled once |

## Verification
The first check is the fast-mode collapse. A model target returns the stale-input value under `clk_sel`, so every entry must equal key0^key1. Swapped slots, a missing XOR, or capture on the wrong tick would leave entries that depend on the swept input.

The second sweep uses normal mode and starts after the first has filled the memory. Its entries must overwrite from address 0 with the ascending repeat pattern, while `full` stays set. A design with a wrong wrap or a broken repeat counter would misplace those entries.

During that second sweep the `x1` pin is changed and `start` is pulsed. A design that re-samples `x1` or restarts would corrupt the pattern or `trial_cnt`.

A monitor watches every second cycle for the `clk_sel` level and for its return to 0 right after the short capture.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_STORE,
        ST_DONE
    } tsc_state_e;
endpackage

// File: rtl/gpl_sweep_seq.sv
module gpl_sweep_seq #(
    parameter int DATA_W = 8,
    parameter int REPS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [DATA_W-1:0] x2,
    output logic              last
);
    localparam int REP_W = (REPS > 1) ? $clog2(REPS) : 1;
    localparam logic [REP_W-1:0] REP_MAX = REP_W'(REPS - 1);

    logic [REP_W-1:0]  rep_q;
    logic [DATA_W-1:0] x2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q <= '0;
            x2_q  <= '0;
        end else if (clear) begin
            rep_q <= '0;
            x2_q  <= '0;
        end else if (step) begin
            if (rep_q == REP_MAX) begin
                rep_q <= '0;
                x2_q  <= x2_q + 1'b1;
            end else begin
                rep_q <= rep_q + 1'b1;
            end
        end
    end

    assign x2   = x2_q;
    assign last = (rep_q == REP_MAX) && (&x2_q);

    // R6
    hold_within_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && rep_q != REP_MAX) |=> x2_q == $past(x2_q));
endmodule

// File: rtl/gpl_capture_pair.sv
module gpl_capture_pair #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap1,
    input  logic              cap2,
    input  logic [DATA_W-1:0] z,
    output logic [DATA_W-1:0] diff
);
    logic [DATA_W-1:0] r1_q, r2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r1_q <= '0;
            r2_q <= '0;
        end else begin
            if (cap1) r1_q <= z;
            if (cap2) r2_q <= z;
        end
    end

    assign diff = r1_q ^ r2_q;

    // R2
    single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap1 && cap2));

    // R3
    second_reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap2 |=> r2_q == $past(z));
endmodule

// File: rtl/gpl_result_ram.sv
module gpl_result_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_addr_q;
    logic              full_q;

    always_ff @(posedge clk) begin
        if (we) mem[wr_addr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            full_q    <= 1'b0;
        end else if (we) begin
            wr_addr_q <= wr_addr_q + 1'b1;
            if (&wr_addr_q) full_q <= 1'b1;
        end
    end

    assign rd_data = mem[rd_addr];
    assign full    = full_q;

    // R5
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> wr_addr_q == $past(wr_addr_q) + 1'b1);

    // R8
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_q |=> full_q);
endmodule

// File: rtl/glitch_pair_logger.sv
module glitch_pair_logger
    import tsc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REPS   = 4,
    parameter int ADDR_W = 10,
    localparam int REP_W   = (REPS > 1) ? $clog2(REPS) : 1,
    localparam int TRIAL_W = DATA_W + REP_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DATA_W-1:0]  x1,
    input  logic               use_fast,
    input  logic               norm_tick,
    input  logic               fast_tick,
    output logic [DATA_W-1:0]  dp_x,
    output logic               dp_slot,
    input  logic [DATA_W-1:0]  dp_z,
    output logic               clk_sel,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic [TRIAL_W-1:0] trial_cnt,
    output logic               busy,
    output logic               done,
    output logic               full
);
    tsc_state_e state_q, state_d;

    logic [DATA_W-1:0]  x1_q;
    logic               mode_q;
    logic [TRIAL_W-1:0] trial_q;
    logic [DATA_W-1:0]  x2;
    logic [DATA_W-1:0]  diff;
    logic               last;
    logic               launch;
    logic               cap1, cap2, step, we;

    assign launch = start && (state_q == ST_IDLE || state_q == ST_DONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FIRST;
            ST_FIRST:  if (norm_tick) state_d = ST_SECOND;
            ST_SECOND: if (mode_q ? fast_tick : norm_tick) state_d = ST_STORE;
            ST_STORE:  state_d = last ? ST_DONE : ST_FIRST;
            ST_DONE:   if (start) state_d = ST_FIRST;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // per-sweep and per-trial registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x1_q    <= '0;
            mode_q  <= 1'b0;
            trial_q <= '0;
        end else if (launch) begin
            x1_q    <= x1;
            mode_q  <= use_fast;
            trial_q <= '0;
        end else if (state_q == ST_STORE) begin
            trial_q <= trial_q + 1'b1;
            if (!last) mode_q <= use_fast;
        end
    end

    // output decode
    always_comb begin
        dp_x    = x1_q;
        dp_slot = 1'b0;
        clk_sel = 1'b0;
        cap1    = 1'b0;
        cap2    = 1'b0;
        step    = 1'b0;
        we      = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FIRST: begin
                busy = 1'b1;
                cap1 = norm_tick;
            end
            ST_SECOND: begin
                busy    = 1'b1;
                dp_x    = x2;
                dp_slot = 1'b1;
                clk_sel = mode_q;
                cap2    = mode_q ? fast_tick : norm_tick;
            end
            ST_STORE: begin
                busy = 1'b1;
                we   = 1'b1;
                step = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign trial_cnt = trial_q;

    gpl_sweep_seq #(.DATA_W(DATA_W), .REPS(REPS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .step  (step),
        .x2    (x2),
        .last  (last)
    );

    gpl_capture_pair #(.DATA_W(DATA_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap1  (cap1),
        .cap2  (cap2),
        .z     (dp_z),
        .diff  (diff)
    );

    gpl_result_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .wdata   (diff),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .full    (full)
    );

    // R4
    sel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel && cap2) |=> !clk_sel);

    // R7
    sweep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> trial_cnt == '0);

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_STORE) |=> trial_cnt == $past(trial_cnt));
endmodule

// File: tb/glitch_pair_logger_test.sv
module glitch_pair_logger_test;
    localparam int DW    = 8;
    localparam int REPS  = 4;
    localparam int AW    = 10;
    localparam int TW    = DW + 2 + 1;
    localparam int NTR   = 256 * REPS;
    localparam logic [7:0] K0 = 8'hE2;
    localparam logic [7:0] K1 = 8'h19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DW-1:0] x1 = '0;
    logic use_fast = 1'b0;
    logic norm_tick = 1'b0, fast_tick = 1'b0;
    logic [DW-1:0] dp_x, dp_z;
    logic dp_slot, clk_sel;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [TW-1:0] trial_cnt;
    logic busy, done, full;

    int checks = 0, fails = 0;
    bit finished = 1'b0;
    bit mon_en = 1'b0;
    logic [7:0] exp_x1 = '0;
    bit exp_mode = 1'b0;
    logic [7:0] lastx = '0;
    bit sel_hit = 1'b0;
    int tick_cnt = 0;

    always #5 clk = ~clk;

    glitch_pair_logger uut (
        .clk(clk), .rst_n(rst_n), .start(start), .x1(x1), .use_fast(use_fast),
        .norm_tick(norm_tick), .fast_tick(fast_tick), .dp_x(dp_x),
        .dp_slot(dp_slot), .dp_z(dp_z), .clk_sel(clk_sel), .rd_addr(rd_addr),
        .rd_data(rd_data), .trial_cnt(trial_cnt), .busy(busy), .done(done),
        .full(full)
    );

    function automatic logic [7:0] subst(input logic [7:0] v);
        return (v * 8'd29 + 8'd101) ^ {v[2:0], v[7:3]};
    endfunction

    // target model: under fast clock the slow substitution path still shows the old input
    always_comb begin
        if (clk_sel) dp_z = subst(lastx) ^ (dp_slot ? K1 : K0);
        else         dp_z = subst(dp_x) ^ (dp_slot ? K1 : K0);
    end

    always @(posedge clk) begin
        if (norm_tick && !dp_slot) lastx <= dp_x;
        sel_hit <= clk_sel && fast_tick;
    end

    always @(negedge clk) begin
        tick_cnt  <= tick_cnt + 1;
        norm_tick <= ((tick_cnt + 1) % 4) == 3;
        fast_tick <= ((tick_cnt + 1) % 2) == 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-cycle monitor of slot, input and clock select
    always @(negedge clk) begin
        if (mon_en && busy) begin
            if (dp_slot == 1'b0) begin
                check(dp_x == exp_x1 && !clk_sel, "R2/R9 first-cycle drive",
                      {dp_x, 7'd0, clk_sel}, {exp_x1, 8'd0});
            end else begin
                check(dp_x == 8'(int'(trial_cnt) / REPS), "R6 second input",
                      dp_x, int'(trial_cnt) / REPS);
                check(clk_sel == exp_mode, "R3 clock select level",
                      clk_sel, exp_mode);
            end
        end
        if (mon_en && sel_hit)
            check(!clk_sel, "R4 select release", clk_sel, 0);
    end

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !full && !clk_sel, "R1 reset flags",
              {busy, done, full, clk_sel}, 0);
        check(trial_cnt == 0, "R1 reset count", trial_cnt, 0);
    endtask

    task automatic t_fast_sweep();
        @(negedge clk);
        x1 = 8'h31; use_fast = 1'b1;
        exp_x1 = 8'h31; exp_mode = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mon_en = 1'b1;
        while (trial_cnt < TW'(NTR / 2)) @(negedge clk);
        check(!full, "R8 not full midway", full, 0);
        wait_done();
        mon_en = 1'b0;
        check(done && !busy, "R7 done after sweep", {done, busy}, 2);
        check(trial_cnt == TW'(NTR), "R7 trial count", trial_cnt, NTR);
        check(full, "R8 full after depth writes", full, 1);
        for (int a = 0; a < NTR; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            #1;
            check(rd_data == (K0 ^ K1), "R5 fast-mode entry", rd_data, K0 ^ K1);
        end
    endtask

    task automatic t_normal_sweep();
        logic [7:0] e;
        @(negedge clk);
        x1 = 8'h9D; use_fast = 1'b0;
        exp_x1 = 8'h9D; exp_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(trial_cnt == 0, "R7 start clears count", trial_cnt, 0);
        check(full, "R8 full stays set", full, 1);
        mon_en = 1'b1;
        while (trial_cnt < TW'(100)) @(negedge clk);
        x1 = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        mon_en = 1'b0;
        check(trial_cnt == TW'(NTR), "R10 start ignored while busy", trial_cnt, NTR);
        for (int a = 0; a < NTR; a++) begin
            @(negedge clk);
            rd_addr = AW'(a);
            #1;
            e = subst(8'h9D) ^ K0 ^ subst(8'(a / REPS)) ^ K1;
            check(rd_data == e, "R5/R6 wrapped normal entry", rd_data, e);
        end
    endtask

    initial begin
        t_reset();
        t_fast_sweep();
        t_normal_sweep();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule